// File: doc/BRIEF.md
# Accumulator Machine Hardwired Control Sequencer

This block is the control unit and datapath of a small single-accumulator processor with 16-bit words and a 4096-word memory. A 4-bit step counter is decoded into one-hot time slots. The slots are ANDed with a one-hot decode of the 3-bit opcode to issue every register transfer. All transfers share one internal word bus. Each instruction runs a fetch, an optional indirection step, and one of seven memory-operand operations: AND, add with carry-out, load, store, jump, call-with-return-save, and increment-and-skip-if-zero. Every instruction ends by clearing the step counter, and control then returns to slot 0.

When the interrupt-pending flag is set at slot 0, a three-slot interrupt sequence runs instead of the fetch. The sequence saves the return address in word 0, continues at word 1, and disarms both the enable flag and the pending flag. Opcode 111 (register and I/O class) only ends the instruction. The program memory is inside the block. A preload port lets a test environment write any word and read any word back without a clock delay.

Top module: `acc_ctrl_top`

## Requirements
- R1: A cycle with `rst` high leaves PC, AR, IR, DR, AC, E, I, the step counter, the interrupt enable and the interrupt-pending flag all at zero on the next edge.
- R2: Without a pending interrupt, slot 0 copies PC into AR. Slot 1 loads IR from the word at AR and adds one to PC. Slot 2 copies IR[11:0] into AR and IR[15] into I.
- R3: Word layout: bit 15 selects indirect addressing, bits 14:12 are the opcode, bits 11:0 the address. At slot 3, an opcode other than 111 with I=1 replaces AR with the low 12 bits of the word at AR. With I=0, AR is kept.
- R4: Opcodes 000 (AND), 001 (add) and 010 (load) read the operand into DR at slot 4. At slot 5 they set AC to AC&DR, AC+DR (carry-out into E) or DR, and the instruction ends after slot 5.
- R5: Opcode 011 writes AC to the word at AR at slot 4 and ends there.
- R6: Opcode 100 loads PC from AR at slot 4 and ends there.
- R7: Opcode 101 writes the zero-extended PC to the word at AR and adds one to AR at slot 4. It copies AR into PC at slot 5 and ends.
- R8: Opcode 110 reads the word into DR at slot 4 and adds one to DR at slot 5. At slot 6 it writes DR back, adds one to PC when DR is zero, and ends.
- R9: Opcode 111 ends at slot 3 and changes no register beyond what the fetch did.
- R10: The pending flag sets when `irq` and the enable are both high while the counter is at 3 or above. If the flag is set at slot 0, the next three slots do AR←0, then word 0←PC with PC←0, then PC←1 with the enable and pending flag cleared, and control returns to slot 0. While the enable is low, `irq` has no effect. `ien_set` sets the enable; the interrupt sequence clearing it wins.
- R11: On every edge out of reset, the step counter either adds one or returns to zero, and it never exceeds 6.
- R12: `pl_we` writes `pl_wdata` to word `pl_addr`, with priority over the core's write. `pl_rdata` always shows the word at `pl_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request level |
| ien_set | input | 1 | Sets the interrupt enable |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | 12 | Preload / readback word address |
| pl_wdata | input | 16 | Preload write data |
| pl_rdata | output | 16 | Word at `pl_addr` |
| pc_o | output | 12 | Program counter |
| ar_o | output | 12 | Address register |
| ir_o | output | 16 | Instruction register |
| dr_o | output | 16 | Data register |
| ac_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag |
| i_o | output | 1 | Indirect bit |
| sc_o | output | 4 | Step counter |
| ien_o | output | 1 | Interrupt enable |
| r_o | output | 1 | Interrupt pending |

## Verification
The embedded properties check, on every cycle, the rules tied to a single slot. These are the counter either stepping or clearing within its bound, the PC step during fetch, the jump and call targets, the skip after a zero increment, the early end of opcode 111, and the state left by the last interrupt slot. Whether operands reach memory correctly, whether indirection picks the right pointer, and whether the carry is right are only visible against the bench's instruction-level model. The same holds for the interrupt's timing relative to `ien_set` and for the saved return address. The bench runs a program that touches every opcode, including indirect forms and a subroutine round trip, and compares every register on each cycle.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OPC_AND = 3'd0;
  localparam logic [OP_W-1:0] OPC_ADD = 3'd1;
  localparam logic [OP_W-1:0] OPC_LDA = 3'd2;
  localparam logic [OP_W-1:0] OPC_STA = 3'd3;
  localparam logic [OP_W-1:0] OPC_BUN = 3'd4;
  localparam logic [OP_W-1:0] OPC_BSA = 3'd5;
  localparam logic [OP_W-1:0] OPC_ISZ = 3'd6;
  localparam logic [OP_W-1:0] OPC_SYS = 3'd7;

  typedef enum logic [2:0] {
    BUS_NONE, BUS_AR, BUS_PC, BUS_DR, BUS_AC, BUS_IR, BUS_MEM
  } bus_sel_e;

  typedef enum logic [1:0] {
    ALU_AND, ALU_ADD, ALU_PASS
  } alu_op_e;
endpackage

// File: rtl/acc_timing.sv
`timescale 1ns/1ps
module acc_timing #(
  parameter int SC_W  = 4,
  parameter int T_NUM = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [SC_W-1:0]  sc,
  output logic [T_NUM-1:0] t
);
  always_ff @(posedge clk) begin
    if (rst || clr) sc <= '0;
    else            sc <= sc + 1'b1;
  end

  for (genvar k = 0; k < T_NUM; k++) begin : g_slot
    assign t[k] = (sc == SC_W'(k));
  end

  // R11
  sc_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sc == '0) || (sc == $past(sc) + 1'b1));

  // R11
  sc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (sc == '0));
endmodule

// File: rtl/acc_opdec.sv
`timescale 1ns/1ps
module acc_opdec #(
  parameter int OPW = 3,
  localparam int NOUT = 1 << OPW
) (
  input  logic [OPW-1:0]  op,
  output logic [NOUT-1:0] d
);
  for (genvar k = 0; k < NOUT; k++) begin : g_dec
    assign d[k] = (op == OPW'(k));
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  alu_op_e           op,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] y,
  output logic              cout
);
  logic [WORD_W:0] sum;
  assign sum = {1'b0, a} + {1'b0, b};

  always_comb begin
    cout = sum[WORD_W];
    unique case (op)
      ALU_AND: y = a & b;
      ALU_ADD: y = sum[WORD_W-1:0];
      default: y = b;
    endcase
  end
endmodule

// File: rtl/acc_mem.sv
`timescale 1ns/1ps
module acc_mem #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [WORD_W-1:0] pl_wdata,
  output logic [WORD_W-1:0] pl_rdata
);
  logic [WORD_W-1:0] ram [0:DEPTH-1];
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;

  always_comb begin
    wr_en   = pl_we | we;
    wr_addr = pl_we ? pl_addr  : addr;
    wr_data = pl_we ? pl_wdata : wdata;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_addr] <= wr_data;
  end

  assign rdata    = ram[addr];
  assign pl_rdata = ram[pl_addr];
endmodule

// File: rtl/acc_ctrl_top.sv
`timescale 1ns/1ps
module acc_ctrl_top
  import acc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SC_W   = 4,
  localparam int WORD_W = ADDR_W + OP_W + 1,
  localparam int T_NUM  = 7,
  localparam int I_BIT  = WORD_W - 1,
  localparam int PAD_W  = WORD_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq,
  input  logic              ien_set,
  input  logic              pl_we,
  input  logic [ADDR_W-1:0] pl_addr,
  input  logic [WORD_W-1:0] pl_wdata,
  output logic [WORD_W-1:0] pl_rdata,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [WORD_W-1:0] ir_o,
  output logic [WORD_W-1:0] dr_o,
  output logic [WORD_W-1:0] ac_o,
  output logic              e_o,
  output logic              i_o,
  output logic [SC_W-1:0]   sc_o,
  output logic              ien_o,
  output logic              r_o
);
  logic [ADDR_W-1:0] pc_q, ar_q;
  logic [WORD_W-1:0] ir_q, dr_q, ac_q;
  logic              e_q, i_q, ien_q, r_q;

  logic [SC_W-1:0]   sc;
  logic [T_NUM-1:0]  t;
  logic [7:0]        d;
  logic [WORD_W-1:0] mem_rd, bus, alu_y;
  logic              alu_c;

  bus_sel_e bus_sel;
  alu_op_e  alu_op;
  logic ld_ar, inc_ar, clr_ar, ld_pc, inc_pc, clr_pc;
  logic ld_ir, ld_i, ld_dr, inc_dr, ld_ac, mem_we, sc_clr, clr_int;
  logic int_cyc, late_slot;

  acc_timing #(.SC_W(SC_W), .T_NUM(T_NUM)) i_timing (
    .clk(clk), .rst(rst), .clr(sc_clr), .sc(sc), .t(t)
  );

  acc_opdec #(.OPW(OP_W)) i_opdec (
    .op(ir_q[I_BIT-1 -: OP_W]), .d(d)
  );

  acc_alu #(.WORD_W(WORD_W)) i_alu (
    .op(alu_op), .a(ac_q), .b(dr_q), .y(alu_y), .cout(alu_c)
  );

  acc_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_mem (
    .clk(clk), .we(mem_we), .addr(ar_q), .wdata(bus), .rdata(mem_rd),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_wdata(pl_wdata), .pl_rdata(pl_rdata)
  );

  assign int_cyc   = r_q & (t[0] | t[1] | t[2]);
  assign late_slot = ~(t[0] | t[1] | t[2]);

  // control decode: slot x opcode
  always_comb begin
    bus_sel = BUS_NONE;
    alu_op  = ALU_PASS;
    ld_ar = 1'b0; inc_ar = 1'b0; clr_ar = 1'b0;
    ld_pc = 1'b0; inc_pc = 1'b0; clr_pc = 1'b0;
    ld_ir = 1'b0; ld_i = 1'b0; ld_dr = 1'b0; inc_dr = 1'b0;
    ld_ac = 1'b0; mem_we = 1'b0; sc_clr = 1'b0; clr_int = 1'b0;
    if (int_cyc) begin
      if (t[0]) clr_ar = 1'b1;
      if (t[1]) begin bus_sel = BUS_PC; mem_we = 1'b1; clr_pc = 1'b1; end
      if (t[2]) begin inc_pc = 1'b1; clr_int = 1'b1; sc_clr = 1'b1; end
    end else begin
      if (t[0]) begin bus_sel = BUS_PC; ld_ar = 1'b1; end
      if (t[1]) begin bus_sel = BUS_MEM; ld_ir = 1'b1; inc_pc = 1'b1; end
      if (t[2]) begin bus_sel = BUS_IR; ld_ar = 1'b1; ld_i = 1'b1; end
      if (t[3]) begin
        if (d[OPC_SYS]) sc_clr = 1'b1;
        else if (i_q) begin bus_sel = BUS_MEM; ld_ar = 1'b1; end
      end
      if (t[4]) begin
        if (d[OPC_AND] | d[OPC_ADD] | d[OPC_LDA] | d[OPC_ISZ]) begin
          bus_sel = BUS_MEM; ld_dr = 1'b1;
        end
        if (d[OPC_STA]) begin bus_sel = BUS_AC; mem_we = 1'b1; sc_clr = 1'b1; end
        if (d[OPC_BUN]) begin bus_sel = BUS_AR; ld_pc = 1'b1; sc_clr = 1'b1; end
        if (d[OPC_BSA]) begin bus_sel = BUS_PC; mem_we = 1'b1; inc_ar = 1'b1; end
      end
      if (t[5]) begin
        if (d[OPC_AND]) begin alu_op = ALU_AND;  ld_ac = 1'b1; sc_clr = 1'b1; end
        if (d[OPC_ADD]) begin alu_op = ALU_ADD;  ld_ac = 1'b1; sc_clr = 1'b1; end
        if (d[OPC_LDA]) begin alu_op = ALU_PASS; ld_ac = 1'b1; sc_clr = 1'b1; end
        if (d[OPC_BSA]) begin bus_sel = BUS_AR; ld_pc = 1'b1; sc_clr = 1'b1; end
        if (d[OPC_ISZ]) inc_dr = 1'b1;
      end
      if (t[6] && d[OPC_ISZ]) begin
        bus_sel = BUS_DR; mem_we = 1'b1; sc_clr = 1'b1;
        inc_pc  = (dr_q == '0);
      end
    end
  end

  // shared word bus
  always_comb begin
    unique case (bus_sel)
      BUS_AR:  bus = {{PAD_W{1'b0}}, ar_q};
      BUS_PC:  bus = {{PAD_W{1'b0}}, pc_q};
      BUS_DR:  bus = dr_q;
      BUS_AC:  bus = ac_q;
      BUS_IR:  bus = ir_q;
      BUS_MEM: bus = mem_rd;
      default: bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0; ar_q <= '0; ir_q <= '0; dr_q <= '0; ac_q <= '0;
      e_q <= 1'b0; i_q <= 1'b0; ien_q <= 1'b0; r_q <= 1'b0;
    end else begin
      if (clr_ar)      ar_q <= '0;
      else if (ld_ar)  ar_q <= bus[ADDR_W-1:0];
      else if (inc_ar) ar_q <= ar_q + 1'b1;

      if (clr_pc)      pc_q <= '0;
      else if (ld_pc)  pc_q <= bus[ADDR_W-1:0];
      else if (inc_pc) pc_q <= pc_q + 1'b1;

      if (ld_ir) ir_q <= bus;
      if (ld_i)  i_q  <= ir_q[I_BIT];

      if (ld_dr)       dr_q <= bus;
      else if (inc_dr) dr_q <= dr_q + 1'b1;

      if (ld_ac) begin
        ac_q <= alu_y;
        if (alu_op == ALU_ADD) e_q <= alu_c;
      end

      if (clr_int)      ien_q <= 1'b0;
      else if (ien_set) ien_q <= 1'b1;

      if (clr_int)                        r_q <= 1'b0;
      else if (irq && ien_q && late_slot) r_q <= 1'b1;
    end
  end

  assign pc_o  = pc_q;
  assign ar_o  = ar_q;
  assign ir_o  = ir_q;
  assign dr_o  = dr_q;
  assign ac_o  = ac_q;
  assign e_o   = e_q;
  assign i_o   = i_q;
  assign sc_o  = sc;
  assign ien_o = ien_q;
  assign r_o   = r_q;

  // R11
  sc_limit_chk: assert property (@(posedge clk) disable iff (rst)
    sc <= SC_W'(T_NUM - 1));

  // R2
  pc_fetch_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (t[1] && !r_q) |=> (pc_q == $past(pc_q) + 1'b1));

  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (t[4] && d[OPC_BUN]) |=> (pc_q == $past(ar_q)) && (sc == '0));

  // R7
  call_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (t[5] && d[OPC_BSA]) |=> (pc_q == $past(ar_q)) && (sc == '0));

  // R8
  isz_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (t[6] && d[OPC_ISZ] && dr_q == '0) |=> (pc_q == $past(pc_q) + 1'b1));

  // R9
  sys_end_chk: assert property (@(posedge clk) disable iff (rst)
    (t[3] && d[OPC_SYS]) |=> (sc == '0) && $stable(ac_q) && $stable(pc_q));

  // R10
  int_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (t[2] && r_q) |=> (pc_q == ADDR_W'(1)) && !ien_q && !r_q && (sc == '0));
endmodule

// File: tb/test_acc_ctrl_top.sv
`timescale 1ns/1ps
module test_acc_ctrl_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic        ien_set = 1'b0;
  logic        pl_we = 1'b0;
  logic [11:0] pl_addr = '0;
  logic [15:0] pl_wdata = '0;
  logic [15:0] pl_rdata;
  logic [11:0] pc_o, ar_o;
  logic [15:0] ir_o, dr_o, ac_o;
  logic        e_o, i_o, ien_o, r_o;
  logic [3:0]  sc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit saw_r  = 1'b0;

  acc_ctrl_top i_acc_ctrl_top (
    .clk(clk), .rst(rst), .irq(irq), .ien_set(ien_set),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_wdata(pl_wdata), .pl_rdata(pl_rdata),
    .pc_o(pc_o), .ar_o(ar_o), .ir_o(ir_o), .dr_o(dr_o), .ac_o(ac_o),
    .e_o(e_o), .i_o(i_o), .sc_o(sc_o), .ien_o(ien_o), .r_o(r_o)
  );

  always #2.5 clk = ~clk;

  // behavioural instruction-slot model
  logic [15:0] m_mem [0:4095];
  int m_pc, m_ar, m_ir, m_dr, m_ac, m_e, m_i, m_sc, m_ien, m_r;
  string m_tag = "R1";
  bit cmp_en = 1'b0;

  always @(posedge clk) begin
    int nsc, op, osc, oien, sum;
    if (rst) begin
      m_pc = 0; m_ar = 0; m_ir = 0; m_dr = 0; m_ac = 0;
      m_e = 0; m_i = 0; m_sc = 0; m_ien = 0; m_r = 0; m_tag = "R1";
      if (pl_we) m_mem[pl_addr] = pl_wdata;
    end else begin
      osc = m_sc; oien = m_ien; nsc = m_sc + 1; op = (m_ir >> 12) & 7;
      if (m_r != 0 && m_sc <= 2) begin
        m_tag = "R10";
        if (m_sc == 0) m_ar = 0;
        else if (m_sc == 1) begin m_mem[m_ar] = 16'(m_pc); m_pc = 0; end
        else begin m_pc = 1; m_ien = 0; m_r = 0; nsc = 0; end
      end else begin
        case (m_sc)
          0: begin m_tag = "R2"; m_ar = m_pc; end
          1: begin m_tag = "R2"; m_ir = m_mem[m_ar]; m_pc = (m_pc + 1) % 4096; end
          2: begin m_tag = "R2"; m_ar = m_ir & 12'hFFF; m_i = (m_ir >> 15) & 1; end
          3: begin
            if (op == 7) begin m_tag = "R9"; nsc = 0; end
            else begin m_tag = "R3"; if (m_i != 0) m_ar = m_mem[m_ar] & 12'hFFF; end
          end
          4: case (op)
            0, 1, 2: begin m_tag = "R4"; m_dr = m_mem[m_ar]; end
            6: begin m_tag = "R8"; m_dr = m_mem[m_ar]; end
            3: begin m_tag = "R5"; m_mem[m_ar] = 16'(m_ac); nsc = 0; end
            4: begin m_tag = "R6"; m_pc = m_ar; nsc = 0; end
            default: begin m_tag = "R7"; m_mem[m_ar] = 16'(m_pc); m_ar = (m_ar + 1) % 4096; end
          endcase
          5: case (op)
            0: begin m_tag = "R4"; m_ac = m_ac & m_dr; nsc = 0; end
            1: begin m_tag = "R4"; sum = m_ac + m_dr; m_ac = sum % 65536; m_e = sum / 65536; nsc = 0; end
            2: begin m_tag = "R4"; m_ac = m_dr; nsc = 0; end
            5: begin m_tag = "R7"; m_pc = m_ar; nsc = 0; end
            default: begin m_tag = "R8"; m_dr = (m_dr + 1) % 65536; end
          endcase
          default: begin
            m_tag = "R8"; m_mem[m_ar] = 16'(m_dr);
            if (m_dr == 0) m_pc = (m_pc + 1) % 4096;
            nsc = 0;
          end
        endcase
      end
      if (ien_set && !(m_r != 0 && osc == 2)) m_ien = 1;
      if (irq && oien != 0 && osc > 2 && !(m_r != 0 && osc == 2)) m_r = 1;
      m_sc = nsc;
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R11", int'(sc_o), m_sc, "step counter");
      chk(m_tag, int'(pc_o), m_pc, "PC");
      chk(m_tag, int'(ar_o), m_ar, "AR");
      chk(m_tag, int'(ir_o), m_ir, "IR");
      chk(m_tag, int'(dr_o), m_dr, "DR");
      chk(m_tag, int'(ac_o), m_ac, "AC");
      chk(m_tag, int'(e_o),  m_e,  "E");
      chk(m_tag, int'(i_o),  m_i,  "I");
      chk("R10", int'(ien_o), m_ien, "IEN");
      chk("R10", int'(r_o),   m_r,   "pending");
      if (r_o) saw_r = 1'b1;
    end
  end

  task automatic load(input int a, input int w);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = 12'(a); pl_wdata = 16'(w);
    @(negedge clk);
    pl_we = 1'b0;
  endtask

  task automatic peek(input int a, input int exp, input string tag);
    @(negedge clk);
    pl_addr = 12'(a);
    #1;
    chk(tag, int'(pl_rdata), exp, "memory word");
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4096; k++) m_mem[k] = '0;
    // vectors and handler
    load(12'h000, 16'h4010);   // jump to main
    load(12'h001, 16'h4060);   // interrupt entry -> handler
    load(12'h060, 16'h2040);   // handler: load 0x00FF
    load(12'h061, 16'hC000);   // return through word 0
    // main
    load(12'h010, 16'h2040);   // R4 load
    load(12'h011, 16'h0041);   // R4 and
    load(12'h012, 16'h1042);   // R4 add with carry
    load(12'h013, 16'h9043);   // R3 indirect add
    load(12'h014, 16'h3045);   // R5 store
    load(12'h015, 16'h6046);   // R8 reaches zero, skips next
    load(12'h016, 16'h2047);
    load(12'h017, 16'h6046);   // R8 no skip
    load(12'h018, 16'h5030);   // R7 call
    load(12'h019, 16'h4019);   // idle loop
    load(12'h031, 16'h7800);   // R9 register class
    load(12'h032, 16'hF080);   // R9 I/O class
    load(12'h033, 16'hC030);   // R3 indirect return
    // data
    load(12'h040, 16'h00FF);
    load(12'h041, 16'h0F0F);
    load(12'h042, 16'hFFF3);
    load(12'h043, 16'h0044);
    load(12'h044, 16'h0005);
    load(12'h046, 16'hFFFF);
    load(12'h047, 16'h1234);
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(pc_o), 0, "PC after reset");
    chk("R1", int'(sc_o), 0, "step counter after reset");
    chk("R1", int'(ac_o), 0, "AC after reset");
    chk("R1", int'(ien_o) + int'(r_o), 0, "interrupt flags after reset");
    rst = 1'b0;
    cmp_en = 1'b1;
    irq = 1'b1;                // R10 ignored while enable is low
    repeat (400) @(negedge clk);
    chk("R10", int'(saw_r), 0, "pending with enable low");
    chk("R7", int'(pc_o) >= 12'h019 ? 1 : 0, 1, "returned from call");
    ien_set = 1'b1;
    @(negedge clk);
    ien_set = 1'b0;
    repeat (300) @(negedge clk);
    irq = 1'b0;
    chk("R10", int'(saw_r), 1, "interrupt taken");
    chk("R4", int'(ac_o), 16'h00FF, "AC after handler");
    chk("R4", int'(e_o), 0, "carry after indirect add");
    cmp_en = 1'b0;
    peek(12'h045, 16'h0007, "R5");
    peek(12'h046, 16'h0001, "R8");
    peek(12'h030, 16'h0019, "R7");
    peek(12'h000, 16'h0019, "R10");
    peek(12'h047, 16'h1234, "R12");
    finish_run();
  end
endmodule